// File: doc/BRIEF.md
# Synchronous FIFO Bridge Master Controller

This controller sits in the fabric of a device attached to an external USB bridge that exposes a synchronous parallel FIFO interface. The bridge supplies the interface clock, at 100 MHz or 66 MHz. The bridge also signals two conditions, both active low. One says that it holds receive data. The other says that it can accept transmit data. The controller owns the read, write and output-enable strobes. It also owns the drive enable of the shared data and byte-enable lines. Every one of these is driven from a register clocked by the bridge clock.

On the fabric side, received words leave through a streaming source port, and words to send enter through a streaming sink port. Traffic always moves in whole blocks of `BLK_WORDS` words. The bridge flags are looked at only when the bus is idle between blocks, so a flag that changes inside a block has no effect on that block.

When both directions are ready at a block boundary, the controller alternates between them. Each change of bus direction passes through an extra released cycle. This gives the data-line drivers time to turn around.

Top module: `fifo_bridge_master`

## Requirements
- R1: While reset is held, `rd_n`, `wr_n` and `oe_n` are 1, and `bus_drive`, `src_valid` and `snk_ready` are 0.
- R2: In a read block, `oe_n` goes low one cycle before `rd_n` goes low. `rd_n` then stays low for exactly `BLK_WORDS` consecutive cycles. `rd_n` and `oe_n` return high on the same edge.
- R3: Each word and byte-enable pattern present on `bus_dq_i`/`bus_be_i` at an edge where `rd_n` is low appears on `src_data`/`src_be`, with `src_valid` high, in the following cycle. Words keep their order.
- R4: `wr_n` is low only while `bus_drive` is 1 and `bus_be_o` is all ones. Sink words appear on `bus_dq_o` in acceptance order, and each write block strobes exactly `BLK_WORDS` words.
- R5: `bus_drive` rises one or more cycles before the first `wr_n` low of a block. `snk_ready` is 1 only while a write block is granted and short of `BLK_WORDS` accepted words.
- R6: `bus_drive` is never 1 while `oe_n` is 0. When the bus changes direction, at least two cycles pass with `oe_n` high and `bus_drive` low.
- R7: `rx_ready_n` and `tx_room_n` are sampled only when a block is started. Raising either flag during a block leaves that block at its full length.
- R8: A read block starts only if `rx_ready_n` is 0 and `src_block_room` is 1. A write block starts only if `tx_room_n` is 0 and `snk_block_avail` is 1.
- R9: When both directions qualify at every boundary, block directions alternate read, write, read and so on.
- R10: A cycle where the sink presents no valid word inside a write block produces a cycle with `wr_n` high. The block then carries on without losing or repeating a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock sourced by the bridge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_dq_i | input | DATA_W | Data lines as seen from the bridge |
| bus_dq_o | output | DATA_W | Data lines driven toward the bridge |
| bus_be_i | input | DATA_W/8 | Byte enables as seen from the bridge |
| bus_be_o | output | DATA_W/8 | Byte enables driven toward the bridge |
| bus_drive | output | 1 | 1 enables the data and byte-enable output drivers |
| rx_ready_n | input | 1 | Low: the bridge holds receive data |
| tx_room_n | input | 1 | Low: the bridge can accept transmit data |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| oe_n | output | 1 | Bridge output enable, active low |
| src_valid | output | 1 | Received word is valid |
| src_data | output | DATA_W | Received word |
| src_be | output | DATA_W/8 | Received byte enables |
| src_block_room | input | 1 | Fabric can absorb a whole block without stalling |
| snk_valid | input | 1 | Transmit word is valid |
| snk_ready | output | 1 | Transmit word is taken on this edge when valid |
| snk_data | input | DATA_W | Transmit word |
| snk_block_avail | input | 1 | Fabric holds at least a whole block to send |

## Verification
The bench drops the bridge flags in the first cycle of a block. A controller that re-sampled them would cut the block short, and the strobe run length would come out below `BLK_WORDS`. It also opens sink bubbles inside a write block. An accept path that ignored `snk_valid` would strobe stale or repeated words, and the scoreboard would flag them. With both directions held ready, it watches direction order and the released cycles between opposite blocks. A fixed priority would repeat a direction, and a missing turnaround state would show a single released cycle. Holding a flag valid while the fabric lacks room or data exposes a start condition that checks only one side.

// File: rtl/fbm_pkg.sv
package fbm_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_TURN,
      ST_RD_OE,
      ST_RD_XFER,
      ST_WR_XFER,
      ST_WR_DRAIN
   } fbm_state_e;
endpackage

// File: rtl/fbm_blk_counter.sv
module fbm_blk_counter #(
   parameter int BLK_WORDS = 256
) (
   input  logic clk,
   input  logic rst_n,
   input  logic step,
   output logic at_last
);
   localparam int CW = (BLK_WORDS > 2) ? $clog2(BLK_WORDS) : 1;
   localparam bit POW2 = (BLK_WORDS & (BLK_WORDS - 1)) == 0;

   logic [CW-1:0] cnt_q;

   generate
      if (POW2) begin : g_wrap
         // power of two: the counter wraps by itself
         assign at_last = &cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    cnt_q <= '0;
            else if (step) cnt_q <= cnt_q + CW'(1);
         end
      end else begin : g_cmp
         assign at_last = (cnt_q == CW'(BLK_WORDS - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                 cnt_q <= '0;
            else if (step && at_last)   cnt_q <= '0;
            else if (step)              cnt_q <= cnt_q + CW'(1);
         end
      end
   endgenerate
endmodule

// File: rtl/fbm_rr_arb.sv
module fbm_rr_arb (
   input  logic rd_ok,
   input  logic wr_ok,
   input  logic last_wr,
   output logic grant_rd,
   output logic grant_wr
);
   // on a tie the direction not served last wins
   always_comb begin
      grant_rd = rd_ok && (!wr_ok || last_wr);
      grant_wr = wr_ok && (!rd_ok || !last_wr);
   end
endmodule

// File: rtl/fifo_bridge_master.sv
module fifo_bridge_master
   import fbm_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int BLK_WORDS = 256
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [DATA_W-1:0]     bus_dq_i,
   output logic [DATA_W-1:0]     bus_dq_o,
   input  logic [DATA_W/8-1:0]   bus_be_i,
   output logic [DATA_W/8-1:0]   bus_be_o,
   output logic                  bus_drive,
   input  logic                  rx_ready_n,
   input  logic                  tx_room_n,
   output logic                  rd_n,
   output logic                  wr_n,
   output logic                  oe_n,
   output logic                  src_valid,
   output logic [DATA_W-1:0]     src_data,
   output logic [DATA_W/8-1:0]   src_be,
   input  logic                  src_block_room,
   input  logic                  snk_valid,
   output logic                  snk_ready,
   input  logic [DATA_W-1:0]     snk_data,
   input  logic                  snk_block_avail
);
   localparam int BE_W = DATA_W / 8;

   generate
      if (!(DATA_W == 16 || DATA_W == 32)) begin : g_bad_width
         $error("fifo_bridge_master: DATA_W must be 16 or 32");
      end
      if (BLK_WORDS < 2) begin : g_bad_blk
         $error("fifo_bridge_master: BLK_WORDS must be at least 2");
      end
   endgenerate

   fbm_state_e state_q, state_d;
   logic       last_wr_q, tgt_wr_q;
   logic       grant_rd, grant_wr;
   logic       rd_last, wr_last;
   logic       accept;

   // flags count only at a block boundary
   fbm_rr_arb u_arb (
      .rd_ok    (!rx_ready_n && src_block_room),
      .wr_ok    (!tx_room_n && snk_block_avail),
      .last_wr  (last_wr_q),
      .grant_rd (grant_rd),
      .grant_wr (grant_wr)
   );

   assign snk_ready = (state_q == ST_WR_XFER);
   assign accept    = snk_ready && snk_valid;

   fbm_blk_counter #(.BLK_WORDS(BLK_WORDS)) u_rd_cnt (
      .clk (clk), .rst_n (rst_n),
      .step (state_q == ST_RD_XFER), .at_last (rd_last)
   );
   fbm_blk_counter #(.BLK_WORDS(BLK_WORDS)) u_wr_cnt (
      .clk (clk), .rst_n (rst_n),
      .step (accept), .at_last (wr_last)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: begin
            if (grant_rd || grant_wr) begin
               if (grant_wr != last_wr_q) state_d = ST_TURN;
               else if (grant_wr)         state_d = ST_WR_XFER;
               else                       state_d = ST_RD_OE;
            end
         end
         ST_TURN:     state_d = tgt_wr_q ? ST_WR_XFER : ST_RD_OE;
         ST_RD_OE:    state_d = ST_RD_XFER;
         ST_RD_XFER:  if (rd_last) state_d = ST_IDLE;
         ST_WR_XFER:  if (accept && wr_last) state_d = ST_WR_DRAIN;
         ST_WR_DRAIN: state_d = ST_IDLE;
         default:     state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         last_wr_q <= 1'b1;
         tgt_wr_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_IDLE && (grant_rd || grant_wr)) begin
            last_wr_q <= grant_wr;
            tgt_wr_q  <= grant_wr;
         end
      end
   end

   // bridge-facing strobes, all from registers fed by next state
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oe_n      <= 1'b1;
         rd_n      <= 1'b1;
         wr_n      <= 1'b1;
         bus_drive <= 1'b0;
         bus_dq_o  <= '0;
         bus_be_o  <= '0;
      end else begin
         oe_n      <= !(state_d == ST_RD_OE || state_d == ST_RD_XFER);
         rd_n      <= !(state_d == ST_RD_XFER);
         bus_drive <= (state_d == ST_WR_XFER || state_d == ST_WR_DRAIN);
         wr_n      <= !accept;
         if (accept) begin
            bus_dq_o <= snk_data;
            bus_be_o <= {BE_W{1'b1}};
         end
      end
   end

   // receive capture: one word per edge with rd_n low
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_valid <= 1'b0;
         src_data  <= '0;
         src_be    <= '0;
      end else begin
         src_valid <= !rd_n;
         src_data  <= bus_dq_i;
         src_be    <= bus_be_i;
      end
   end

   AST_RD_UNDER_OE: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n |-> !oe_n); // R2
   AST_OE_LEADS_RD: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rd_n) |-> !$past(oe_n)); // R2
   AST_RD_OE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_n) |-> oe_n); // R2
   AST_SRC_FOLLOWS_RD: assert property (@(posedge clk) disable iff (!rst_n)
      src_valid |-> !$past(rd_n)); // R3
   AST_WR_WHILE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_n |-> (bus_drive && &bus_be_o)); // R4
   AST_DRIVE_BEFORE_WR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_drive) |-> wr_n); // R5
   AST_SNK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      snk_ready |-> (bus_drive && oe_n)); // R5
   AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
      bus_drive |-> oe_n); // R6
   AST_TURN_TO_WR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_drive) |-> ($past(oe_n) && $past(oe_n, 2))); // R6
   AST_TURN_TO_RD: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(oe_n) |-> (!$past(bus_drive) && !$past(bus_drive, 2))); // R6
endmodule

// File: tb/fifo_bridge_master_tb.sv
module fifo_bridge_master_tb_top;
   localparam int DW  = 32;
   localparam int BW  = DW / 8;
   localparam int BLK = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [DW-1:0] bus_dq_i = '0, bus_dq_o, src_data, snk_data = '0;
   logic [BW-1:0] bus_be_i = '0, bus_be_o, src_be;
   logic bus_drive, rd_n, wr_n, oe_n, src_valid, snk_ready;
   logic rx_ready_n = 1'b1, tx_room_n = 1'b1;
   logic src_block_room = 1'b0, snk_valid = 1'b0, snk_block_avail = 1'b0;

   always #2 clk = ~clk;

   fifo_bridge_master #(.DATA_W(DW), .BLK_WORDS(BLK)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .bus_dq_i(bus_dq_i), .bus_dq_o(bus_dq_o),
      .bus_be_i(bus_be_i), .bus_be_o(bus_be_o), .bus_drive(bus_drive),
      .rx_ready_n(rx_ready_n), .tx_room_n(tx_room_n),
      .rd_n(rd_n), .wr_n(wr_n), .oe_n(oe_n),
      .src_valid(src_valid), .src_data(src_data), .src_be(src_be),
      .src_block_room(src_block_room),
      .snk_valid(snk_valid), .snk_ready(snk_ready), .snk_data(snk_data),
      .snk_block_avail(snk_block_avail)
   );

   int n_chk = 0, n_bad = 0;
   logic [DW+BW-1:0] rx_q[$];
   logic [DW-1:0]    tx_q[$];

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // monitor state
   bit mon_on = 0, both_phase = 0, bubble_en = 0, pend_take = 0;
   int ridx = 0, widx = 0, cyc = 0;
   int idle_run = 0, last_dir = 0, blocks_rd = 0, blocks_wr = 0;
   int rd_run = 0, wr_words = 0, wr_holes = 0;
   logic prev_rd_n = 1, prev_oe_n = 1, prev_drive = 0;
   bit saw_oe = 0, saw_drive = 0;

   always @(negedge clk) begin
      cyc++;
      if (mon_on) begin
         int cur;
         // sink driver: retire word taken at the last edge
         if (pend_take) begin
            tx_q.push_back(snk_data);
            widx++;
         end
         snk_valid = snk_block_avail && !(bubble_en && (cyc % 4 == 1));
         snk_data  = 32'hA500_0000 + DW'(widx);
         pend_take = snk_valid && snk_ready;

         // receive scoreboard (R3)
         if (src_valid) begin
            if (rx_q.size() == 0)
               chk(0, "R3", "unexpected src word", longint'(src_data), 0);
            else begin
               logic [DW+BW-1:0] e;
               e = rx_q.pop_front();
               chk({src_be, src_data} == e, "R3", "src word", longint'({src_be, src_data}), longint'(e));
            end
         end
         // transmit scoreboard (R4)
         if (!wr_n) begin
            chk(bus_drive && (&bus_be_o), "R4", "wr_n low without drive/all enables",
                longint'({bus_drive, bus_be_o}), longint'({1'b1, {BW{1'b1}}}));
            if (tx_q.size() == 0)
               chk(0, "R4", "unexpected write word", longint'(bus_dq_o), 0);
            else begin
               logic [DW-1:0] e;
               e = tx_q.pop_front();
               chk(bus_dq_o == e, "R4", "write word", longint'(bus_dq_o), longint'(e));
            end
            wr_words++;
         end else if (bus_drive && prev_drive && wr_words > 0) wr_holes++;   // R10

         // read strobe shape (R2, R7)
         if (!rd_n && prev_rd_n)
            chk(!prev_oe_n, "R2", "oe_n low one cycle before rd_n", longint'(prev_oe_n), 0);
         if (!rd_n) rd_run++;
         if (rd_n && !prev_rd_n) begin
            chk(rd_run == BLK, "R7", "read block length", rd_run, BLK);
            chk(oe_n, "R2", "oe_n released with rd_n", longint'(oe_n), 1);
            rd_run = 0;
         end
         if (!bus_drive && prev_drive) begin
            chk(wr_words == BLK, "R4", "write block length", wr_words, BLK);
            wr_words = 0;
         end
         if (!oe_n && bus_drive) chk(0, "R6", "drive while oe_n low", 1, 0);

         // block starts, turnaround and alternation (R5, R6, R9)
         cur = !oe_n ? 1 : (bus_drive ? 2 : 0);
         if (!oe_n) saw_oe = 1;
         if (bus_drive) saw_drive = 1;
         if (cur == 0) idle_run++;
         else if (idle_run > 0) begin
            if (cur == 2) chk(wr_n, "R5", "drive ahead of first wr_n", longint'(wr_n), 1);
            if (last_dir != 0 && cur != last_dir)
               chk(idle_run >= 2, "R6", "released cycles at direction change", idle_run, 2);
            if (both_phase)
               chk(cur != last_dir, "R9", "direction alternation", cur, 3 - last_dir);
            if (cur == 1) blocks_rd++; else blocks_wr++;
            last_dir = cur;
            idle_run = 0;
         end
         prev_rd_n = rd_n; prev_oe_n = oe_n; prev_drive = bus_drive;

         // bridge model: present a word for each edge with rd_n low
         if (!rd_n) begin
            bus_dq_i = 32'h5A00_0000 + DW'(ridx);
            bus_be_i = ridx[0] ? {BW{1'b1}} : BW'(3);
            rx_q.push_back({bus_be_i, bus_dq_i});
            ridx++;
         end
      end
   end

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      chk(0, "WD", "watchdog expired", 0, 1);
      finish_run();
   end

   initial begin
      int b0;
      repeat (3) @(negedge clk);
      // R1
      chk(rd_n && wr_n && oe_n, "R1", "strobes in reset", longint'({rd_n, wr_n, oe_n}), 7);
      chk(!bus_drive && !src_valid && !snk_ready, "R1", "drive/valid/ready in reset",
          longint'({bus_drive, src_valid, snk_ready}), 0);
      rst_n = 1'b1;
      mon_on = 1;

      // R8: flags asserted but fabric not ready
      rx_ready_n = 0; tx_room_n = 0;
      repeat (30) @(negedge clk);
      chk(!saw_oe, "R8", "read started without src room", longint'(saw_oe), 0);
      chk(!saw_drive, "R8", "write started without sink block", longint'(saw_drive), 0);

      // R7: read block, flag dropped inside block
      tx_room_n = 1; src_block_room = 1;
      while (rd_n) @(negedge clk);
      rx_ready_n = 1;
      repeat (BLK + 10) @(negedge clk);
      chk(blocks_rd == 1, "R7", "read blocks after flag drop", blocks_rd, 1);

      // R10/R7: write block with sink bubbles, flag dropped inside block
      bubble_en = 1; tx_room_n = 0; snk_block_avail = 1;
      while (!bus_drive) @(negedge clk);
      tx_room_n = 1;
      repeat (3 * BLK) @(negedge clk);
      chk(blocks_wr == 1, "R7", "write blocks after flag drop", blocks_wr, 1);
      chk(wr_holes > 0, "R10", "write holes seen for sink bubbles", wr_holes, 1);
      bubble_en = 0;

      // R9: both directions ready
      both_phase = 1;
      b0 = blocks_rd + blocks_wr;
      rx_ready_n = 0; tx_room_n = 0;
      while (blocks_rd + blocks_wr < b0 + 6) @(negedge clk);
      rx_ready_n = 1; tx_room_n = 1;
      repeat (3 * BLK) @(negedge clk);
      both_phase = 0;
      chk(blocks_rd == 4 && blocks_wr == 4, "R9", "block counts after alternation",
          longint'({blocks_rd[15:0], blocks_wr[15:0]}), longint'({16'd4, 16'd4}));
      chk(rx_q.size() == 0, "R3", "receive words left undelivered", rx_q.size(), 0);
      chk(tx_q.size() == 0, "R4", "accepted words left unwritten", tx_q.size(), 0);
      chk(!snk_ready, "R5", "snk_ready low outside a block", longint'(snk_ready), 0);
      finish_run();
   end
endmodule